// File: doc/BRIEF.md
# Dual-Mode PWM Channel Counter

This block is one 8-bit pulse-width channel. A free-running count register advances on a per-channel clock-enable tick. It is compared against an active period and an active duty value to produce a single waveform output. Software writes the period and duty into holding registers. The values move into the active registers only at a period boundary or when software writes the counter. As a result, a running waveform is never cut short by a half-applied setting.

Two alignments are selectable:

- **Edge-aligned:** the count runs from zero up to the period and restarts.
- **Center-aligned:** the count climbs to the period, reverses, descends to zero and climbs again.

A polarity input sets the level that opens each period. A special-mode flag with two test bits can suppress the clearing action of a counter write, and can suppress the restart that a period match causes in edge-aligned operation.

Top module: `pwm_chan`

## Requirements
- R1: After reset the count, both holding registers and both active registers are 0x00, and `pwm_o` equals the inverse of `pol_i`, because a zero duty applies.
- R2: A bus write with `bus_addr_i` = 0 clears the count to 0x00 whatever data it carries. It wins over a tick in the same cycle. `bus_rdata_o` always presents the current count, and reading it alters nothing.
- R3: Bus writes with `bus_addr_i` = 1 (period) and 2 (duty) only fill holding registers. The active pair is copied from them on a counter write, or at a period boundary. The boundary is the match in edge-aligned mode, or the step onto zero in center-aligned mode.
- R4: When `special_i` and `tst_no_wr_rst_i` are both high, a counter write leaves the count unchanged. With `special_i` low, that test bit has no effect.
- R5: The count changes by stepping only in cycles where `en_i` and `tick_i` are both high. Dropping `en_i` keeps the count, and counting resumes from it.
- R6: Edge-aligned (`center_i` = 0): a step taken while the count equals the active period sets the count to 0x00. Otherwise a step adds one.
- R7: When `special_i` and `tst_no_per_rst_i` are both high in edge-aligned mode, a period match does not restart the count; it keeps incrementing. With `special_i` low, the bit has no effect.
- R8: Center-aligned (`center_i` = 1): the count rises by one per step until it equals the period. The next step reverses it downward. On reaching 0x00 it rises again. A counter write restarts it rising from zero.
- R9: `pwm_o` equals `pol_i` while the count is below the active duty and the inverse of `pol_i` once the count reaches it. It follows the registered count combinationally.
- R10: An active duty of 0x00 holds `pwm_o` at the inverse of `pol_i`. A nonzero active duty at or above the active period holds `pwm_o` at `pol_i` for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Channel clock-enable tick |
| en_i | input | 1 | Channel enable |
| center_i | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| pol_i | input | 1 | Level that opens each period |
| special_i | input | 1 | Special-mode flag qualifying the test bits |
| tst_no_wr_rst_i | input | 1 | Test bit: counter write does not clear |
| tst_no_per_rst_i | input | 1 | Test bit: edge-aligned match does not restart |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | 0 counter, 1 period, 2 duty |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Current count |
| pwm_o | output | 1 | PWM waveform |

## Verification
The hardest situation to reach from the ports is a holding register being rewritten in the middle of a running period. The old active period must keep governing the count until the boundary, and the new one must take over exactly there. The stimulus gets there as follows. It starts an edge-aligned period of nine and steps it part way. It then writes a shorter period, steps past where the new value would have matched, and keeps stepping through the old match into a following period of the new length. A second directed case changes the duty mid-period and then writes the counter with nonzero data. This shows that the write both clears the count and forces the reload at once.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_CNT  = 2'd0,
    REG_PER  = 2'd1,
    REG_DUTY = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         per_we_i,
  input  logic         duty_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] per_o,
  output logic [W-1:0] duty_o
);
  logic [W-1:0] per_buf_q, duty_buf_q, per_act_q, duty_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_buf_q  <= '0;
      duty_buf_q <= '0;
    end else begin
      if (per_we_i)  per_buf_q  <= wdata_i;
      if (duty_we_i) duty_buf_q <= wdata_i;
    end
  end

  // active pair only moves on load (boundary or counter write)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_act_q  <= '0;
      duty_act_q <= '0;
    end else if (load_i) begin
      per_act_q  <= per_buf_q;
      duty_act_q <= duty_buf_q;
    end
  end

  assign per_o  = per_act_q;
  assign duty_o = duty_act_q;

  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (per_act_q == $past(per_buf_q)) && (duty_act_q == $past(duty_buf_q)));

  assert_no_stray_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(per_act_q) && $stable(duty_act_q));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         center_i,
  input  logic         cnt_wr_i,
  input  logic         wr_blk_i,
  input  logic         per_blk_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         per_start_o
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;
  logic         edge_match;

  assign edge_match = (cnt_q == per_i);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (cnt_wr_i) begin
      if (!wr_blk_i) begin
        cnt_d = ZERO;
        up_d  = 1'b1;
      end
    end else if (step_i) begin
      if (!center_i) begin
        up_d  = 1'b1;
        cnt_d = (edge_match && !per_blk_i) ? ZERO : cnt_q + ONE;
      end else if (up_q) begin
        if (cnt_q >= per_i) begin
          up_d  = 1'b0;
          cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == ZERO) begin
          up_d = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
          if (cnt_q == ONE) up_d = 1'b1;
        end
      end
    end
  end

  always_comb begin
    per_start_o = 1'b0;
    if (step_i && !cnt_wr_i) begin
      if (!center_i) per_start_o = edge_match;
      else           per_start_o = (cnt_q != ZERO) && (cnt_d == ZERO);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;

  assert_wr_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i && !wr_blk_i) |=> (cnt_q == ZERO));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !cnt_wr_i) |=> $stable(cnt_q));

  assert_edge_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !cnt_wr_i && !center_i && edge_match && !per_blk_i) |=> (cnt_q == ZERO));

  assert_edge_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !cnt_wr_i && !center_i && per_blk_i) |=> (cnt_q == $past(cnt_q) + ONE));

  assert_center_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !cnt_wr_i && center_i && !up_q && (cnt_q != ZERO)) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] duty_i,
  input  logic         pol_i,
  output logic         pwm_o
);
  logic open_phase;

  // nonzero duty at/above period pins the opening level
  assign open_phase = (cnt_i < duty_i) || ((duty_i != '0) && (duty_i >= per_i));
  assign pwm_o      = open_phase ? pol_i : ~pol_i;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              center_i,
  input  logic              pol_i,
  input  logic              special_i,
  input  logic              tst_no_wr_rst_i,
  input  logic              tst_no_per_rst_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  output logic              pwm_o
);
  logic         step, cnt_wr, wr_blk, per_blk, per_start;
  logic [W-1:0] cnt, per_act, duty_act;

  assign step    = en_i & tick_i;
  assign cnt_wr  = bus_we_i && (bus_addr_i == REG_CNT);
  assign wr_blk  = special_i & tst_no_wr_rst_i;
  assign per_blk = special_i & tst_no_per_rst_i;

  pwm_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .per_we_i  (bus_we_i && (bus_addr_i == REG_PER)),
    .duty_we_i (bus_we_i && (bus_addr_i == REG_DUTY)),
    .wdata_i   (bus_wdata_i),
    .load_i    (cnt_wr | per_start),
    .per_o     (per_act),
    .duty_o    (duty_act)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .center_i    (center_i),
    .cnt_wr_i    (cnt_wr),
    .wr_blk_i    (wr_blk),
    .per_blk_i   (per_blk),
    .per_i       (per_act),
    .cnt_o       (cnt),
    .per_start_o (per_start)
  );

  pwm_out #(.W(W)) u_out (
    .cnt_i  (cnt),
    .per_i  (per_act),
    .duty_i (duty_act),
    .pol_i  (pol_i),
    .pwm_o  (pwm_o)
  );

  assign bus_rdata_o = cnt;

  assert_blocked_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr && special_i && tst_no_wr_rst_i) |=> $stable(bus_rdata_o));

  assert_duty_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act == '0) |-> (pwm_o == ~pol_i));

  assert_duty_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((duty_act != '0) && (duty_act >= per_act)) |-> (pwm_o == pol_i));
endmodule

// File: tb/pwm_chan_bench.sv
module pwm_chan_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, en_i = 1'b1, center_i = 1'b0, pol_i = 1'b0;
  logic       special_i = 1'b0, tst_no_wr_rst_i = 1'b0, tst_no_per_rst_i = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic [7:0] bus_rdata_o;
  logic       pwm_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  pwm_chan u_pwm_chan (
    .clk_i (clk), .rst_ni (rst_ni), .tick_i (tick_i), .en_i (en_i),
    .center_i (center_i), .pol_i (pol_i), .special_i (special_i),
    .tst_no_wr_rst_i (tst_no_wr_rst_i), .tst_no_per_rst_i (tst_no_per_rst_i),
    .bus_we_i (bus_we_i), .bus_addr_i (bus_addr_i), .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o), .pwm_o (pwm_o)
  );

  typedef struct packed {
    logic       center;
    logic [7:0] per;
    logic [7:0] duty;
    logic       pol;
    logic [8:0] steps;
    logic [7:0] cnt;
    logic       pwm;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd9,   8'd3,   1'b1, 9'd2,   8'd2,   1'b1},
    '{1'b0, 8'd9,   8'd3,   1'b1, 9'd5,   8'd5,   1'b0},
    '{1'b0, 8'd9,   8'd3,   1'b1, 9'd10,  8'd0,   1'b1},
    '{1'b0, 8'd9,   8'd3,   1'b1, 9'd12,  8'd2,   1'b1},
    '{1'b0, 8'd9,   8'd0,   1'b1, 9'd4,   8'd4,   1'b0},
    '{1'b0, 8'd9,   8'd9,   1'b0, 9'd9,   8'd9,   1'b0},
    '{1'b0, 8'd9,   8'd9,   1'b0, 9'd3,   8'd3,   1'b0},
    '{1'b1, 8'd5,   8'd2,   1'b1, 9'd5,   8'd5,   1'b0},
    '{1'b1, 8'd5,   8'd2,   1'b1, 9'd6,   8'd4,   1'b0},
    '{1'b1, 8'd5,   8'd2,   1'b1, 9'd8,   8'd2,   1'b0},
    '{1'b1, 8'd5,   8'd2,   1'b1, 9'd9,   8'd1,   1'b1},
    '{1'b1, 8'd5,   8'd2,   1'b1, 9'd10,  8'd0,   1'b1},
    '{1'b1, 8'd5,   8'd2,   1'b1, 9'd11,  8'd1,   1'b1},
    '{1'b0, 8'd255, 8'd128, 1'b0, 9'd200, 8'd200, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic step(input int n);
    en_i = 1'b1; tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic setup(input logic c, input logic [7:0] p, input logic [7:0] d, input logic pl);
    center_i = c; pol_i = pl;
    wr(2'd1, p);
    wr(2'd2, d);
    wr(2'd0, 8'h5A);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset count", bus_rdata_o, 0);
    check("R1 reset pwm pol0", pwm_o, 1);
    pol_i = 1'b1; #1;
    check("R1 reset pwm pol1", pwm_o, 0);

    // table: R6 edge restart, R8 center turn, R9 compare, R10 constants
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].center, VECS[i].per, VECS[i].duty, VECS[i].pol);
      step(int'(VECS[i].steps));
      check($sformatf("R6/R8 vec%0d count", i), bus_rdata_o, VECS[i].cnt);
      check($sformatf("R9/R10 vec%0d pwm", i), pwm_o, VECS[i].pwm);
    end

    // R5: no step without both enable and tick, count kept and resumed
    setup(1'b0, 8'd9, 8'd3, 1'b1);
    step(3);
    en_i = 1'b0; tick_i = 1'b1;
    repeat (4) @(negedge clk);
    tick_i = 1'b0;
    check("R5 disabled hold", bus_rdata_o, 3);
    en_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 no tick hold", bus_rdata_o, 3);
    step(2);
    check("R5 resume", bus_rdata_o, 5);

    // R3: period buffer change waits for boundary
    setup(1'b0, 8'd9, 8'd3, 1'b1);
    step(2);
    wr(2'd1, 8'd4);
    step(4);
    check("R3 old period governs", bus_rdata_o, 6);
    step(8);
    check("R3 new period in effect", bus_rdata_o, 4);
    step(1);
    check("R3 restart at new period", bus_rdata_o, 0);

    // R2/R3: counter write with data clears and reloads duty
    setup(1'b0, 8'd9, 8'd3, 1'b1);
    step(2);
    wr(2'd2, 8'd7);
    wr(2'd0, 8'hAB);
    check("R2 write clears", bus_rdata_o, 0);
    step(5);
    check("R3 duty reloaded by write", pwm_o, 1);

    // R2: write beats tick in same cycle
    bus_we_i = 1'b1; bus_addr_i = 2'd0; bus_wdata_i = 8'h33; tick_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0; tick_i = 1'b0;
    check("R2 write priority", bus_rdata_o, 0);

    // R4: blocked counter write
    step(5);
    special_i = 1'b1; tst_no_wr_rst_i = 1'b1;
    wr(2'd0, 8'h00);
    check("R4 blocked write", bus_rdata_o, 5);
    special_i = 1'b0;
    wr(2'd0, 8'h00);
    check("R4 bit ignored outside special", bus_rdata_o, 0);
    tst_no_wr_rst_i = 1'b0;

    // R7: period restart suppressed only in special mode
    setup(1'b0, 8'd4, 8'd2, 1'b1);
    special_i = 1'b1; tst_no_per_rst_i = 1'b1;
    step(6);
    check("R7 no restart", bus_rdata_o, 6);
    special_i = 1'b0;
    wr(2'd0, 8'h00);
    step(6);
    check("R7 bit ignored outside special", bus_rdata_o, 1);
    tst_no_per_rst_i = 1'b0;

    finish_run();
  end
endmodule